// File: doc/BRIEF.md
# Programmable Panel Clock Divider

This block produces the pixel-rate clock for a display panel from the controller's reference clock. Software writes a divisor value `D` as two equal-width fields, an upper and a lower half, which are joined with the lower field as the least significant part. The panel clock period is then `D + 2` reference cycles. A separate strobe, one reference cycle wide, marks each rising edge of the panel clock so that pixel logic in the reference domain can act on it without detecting edges itself.

Passive-matrix (STN) panels need a minimum divisor, because the pixel path behind this block has a fixed latency. That minimum depends on whether the panel is colour, mono with a 4-bit bus or mono with an 8-bit bus, and on whether it is driven as one or two panels. The block raises any smaller programmed value to that minimum. For active-matrix (TFT) panels no minimum applies, and a bypass input passes the reference clock straight through.

A new divisor or mode is sampled only at the end of the current output period, so the running high and low phases always finish with their old lengths.

Top module: `panel_clk_div`

## Requirements
- R1: With bypass low, the panel clock period is `E + 2` reference cycles, where `E` is the effective divisor. The programmed divisor is `{pcd_hi_i, pcd_lo_i}`, so with the default widths it spans 0 to 1023 and the period spans 2 to 1025.
- R2: Within each period the panel clock is high for `floor((E+2)/2)` reference cycles and low for the rest.
- R3: Mode code 0 selects colour STN. Its minimum effective divisor is 1 with `dual_i` low and 4 with `dual_i` high. A smaller programmed value is replaced by the minimum.
- R4: Mode code 1 selects mono STN on a 4-bit bus. Its minimum effective divisor is 2 for a single panel and 6 for a dual panel.
- R5: Mode code 2 selects mono STN on an 8-bit bus. Its minimum effective divisor is 6 for a single panel and 14 for a dual panel. Values at or above the minimum are used unchanged.
- R6: Mode code 3 selects TFT. No minimum applies, so a programmed 0 gives a period of 2.
- R7: While `bypass_i` is high, `panel_clk_o` follows `clk_i` and `pix_rise_o` stays high. After `bypass_i` falls, the first divided rising edge and its strobe appear on the second reference edge.
- R8: Outside bypass, `pix_rise_o` is high for exactly one reference cycle per period. That cycle is the first cycle of the high phase of `panel_clk_o`.
- R9: The divisor, mode and dual select are sampled only at a period boundary. A change made during a period leaves that period at its old length.
- R10: While reset is asserted, and with bypass low, `panel_clk_o` and `pix_rise_o` are low. After reset is released, the first strobe appears on the fourth reference edge (two synchroniser stages, then one edge each for the counter and the output register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pcd_hi_i | input | FIELD_W | Upper half of the programmed divisor |
| pcd_lo_i | input | FIELD_W | Lower half of the programmed divisor |
| bypass_i | input | 1 | Pass the reference clock straight through (TFT) |
| dual_i | input | 1 | Dual-panel drive, which selects the larger minimum |
| mode_i | input | 2 | 0 colour STN, 1 mono 4-bit, 2 mono 8-bit, 3 TFT |
| panel_clk_o | output | 1 | Panel clock |
| pix_rise_o | output | 1 | One-cycle strobe at each panel clock rising edge |

## Verification
The bench builds the block with its default parameters: 5-bit fields, so a 10-bit divisor, and a two-stage reset synchroniser. With these values every minimum in all six mode and panel combinations can be reached, as can the largest period of 1025 cycles and the exact latency after reset release. Random configurations are drawn mostly below 24, so that the clamp is often active, and sometimes across the full 10-bit range. Directed cases cover odd and even periods, a divisor change in mid-period, and entering and leaving bypass.

// File: rtl/pcd_pkg.sv
`timescale 1ns/1ps
package pcd_pkg;

  typedef enum logic [1:0] {
    PM_COLOR = 2'd0,
    PM_MONO4 = 2'd1,
    PM_MONO8 = 2'd2,
    PM_TFT   = 2'd3
  } panel_mode_e;

  localparam int unsigned FLOOR_W = 5;

  // smallest divisor the pixel path tolerates for each panel setup
  function automatic logic [FLOOR_W-1:0] mode_floor(panel_mode_e m, logic dual);
    logic [FLOOR_W-1:0] f;
    case (m)
      PM_COLOR: f = dual ? 5'd4  : 5'd1;
      PM_MONO4: f = dual ? 5'd6  : 5'd2;
      PM_MONO8: f = dual ? 5'd14 : 5'd6;
      default:  f = 5'd0;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/pcd_rst_sync.sv
`timescale 1ns/1ps
module pcd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/pcd_floor.sv
`timescale 1ns/1ps
module pcd_floor
  import pcd_pkg::*;
#(
  parameter int unsigned DIV_W = 10
) (
  input  logic [DIV_W-1:0] pcd_i,
  input  panel_mode_e      mode_i,
  input  logic             dual_i,
  output logic [DIV_W-1:0] pcd_o
);
  logic [DIV_W-1:0] lim;

  always_comb begin
    lim   = DIV_W'(mode_floor(mode_i, dual_i));
    pcd_o = (pcd_i < lim) ? lim : pcd_i;
  end
endmodule

// File: rtl/pcd_period_ctr.sv
`timescale 1ns/1ps
module pcd_period_ctr #(
  parameter int unsigned DIV_W = 10,
  localparam int unsigned CNT_W = DIV_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic [DIV_W-1:0] pcd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] len_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] len_q, len_n;
  logic             wrap;

  // the reset length of 1 makes the very first cycle a boundary
  always_comb begin
    wrap  = (cnt_q >= len_q - CNT_W'(1));
    cnt_n = cnt_q + CNT_W'(1);
    len_n = len_q;
    if (hold_i) begin
      cnt_n = '0;
      len_n = CNT_W'(1);
    end else if (wrap) begin
      cnt_n = '0;
      len_n = CNT_W'(pcd_i) + CNT_W'(2);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      len_q <= CNT_W'(1);
    end else begin
      cnt_q <= cnt_n;
      len_q <= len_n;
    end
  end

  assign cnt_o = cnt_q;
  assign len_o = len_q;

  assert_cnt_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < len_q);

  assert_len_kept_midperiod_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && (cnt_q + CNT_W'(1) < len_q)) |=> $stable(len_q));
endmodule

// File: rtl/pcd_out_stage.sv
`timescale 1ns/1ps
module pcd_out_stage #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bypass_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             panel_clk_o,
  output logic             pix_rise_o
);
  logic [CNT_W-1:0] hi_len;
  logic             clk_q, clk_n;
  logic             rise_q, rise_n;

  always_comb begin
    hi_len = len_i >> 1;
    clk_n  = bypass_i ? 1'b0 : (cnt_i < hi_len);
    rise_n = clk_n & ~clk_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q  <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      clk_q  <= clk_n;
      rise_q <= rise_n;
    end
  end

  assign panel_clk_o = bypass_i ? clk_i : clk_q;
  assign pix_rise_o  = bypass_i | rise_q;

  assert_rise_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_q |=> !rise_q);

  assert_rise_in_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_q |-> clk_q);
endmodule

// File: rtl/panel_clk_div.sv
`timescale 1ns/1ps
module panel_clk_div
  import pcd_pkg::*;
#(
  parameter int unsigned FIELD_W     = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FIELD_W-1:0] pcd_hi_i,
  input  logic [FIELD_W-1:0] pcd_lo_i,
  input  logic               bypass_i,
  input  logic               dual_i,
  input  logic [1:0]         mode_i,
  output logic               panel_clk_o,
  output logic               pix_rise_o
);
  localparam int unsigned DIV_W = 2 * FIELD_W;
  localparam int unsigned CNT_W = DIV_W + 1;

  logic             rst_n;
  logic [DIV_W-1:0] pcd_raw, pcd_eff;
  logic [CNT_W-1:0] cnt, len;
  panel_mode_e      mode;

  assign pcd_raw = {pcd_hi_i, pcd_lo_i};
  assign mode    = panel_mode_e'(mode_i);

  pcd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n)
  );

  pcd_floor #(.DIV_W(DIV_W)) u_floor (
    .pcd_i (pcd_raw),
    .mode_i(mode),
    .dual_i(dual_i),
    .pcd_o (pcd_eff)
  );

  pcd_period_ctr #(.DIV_W(DIV_W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .hold_i(bypass_i),
    .pcd_i (pcd_eff),
    .cnt_o (cnt),
    .len_o (len)
  );

  pcd_out_stage #(.CNT_W(CNT_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .bypass_i   (bypass_i),
    .cnt_i      (cnt),
    .len_i      (len),
    .panel_clk_o(panel_clk_o),
    .pix_rise_o (pix_rise_o)
  );

  assert_floor_color_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode == PM_COLOR) |-> (pcd_eff >= (dual_i ? DIV_W'(4) : DIV_W'(1))));

  assert_floor_mono4_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode == PM_MONO4) |-> (pcd_eff >= (dual_i ? DIV_W'(6) : DIV_W'(2))));

  assert_floor_mono8_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode == PM_MONO8) |-> (pcd_eff >= (dual_i ? DIV_W'(14) : DIV_W'(6))));

  assert_bypass_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    bypass_i |-> pix_rise_o);
endmodule

// File: tb/panel_clk_div_bench.sv
`timescale 1ns/1ps
module panel_clk_div_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [FW-1:0] hi, lo;
  logic          byp, dual;
  logic [1:0]    mode;
  logic          pclk, rise;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  panel_clk_div u_panel_clk_div (
    .clk_i(clk), .rst_ni(rst_n), .pcd_hi_i(hi), .pcd_lo_i(lo),
    .bypass_i(byp), .dual_i(dual), .mode_i(mode),
    .panel_clk_o(pclk), .pix_rise_o(rise)
  );

  function automatic int floor_of(int m, bit d);
    case (m)
      0: return d ? 4 : 1;
      1: return d ? 6 : 2;
      2: return d ? 14 : 6;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_len(int m, bit d, int pcd);
    int f = floor_of(m, d);
    return ((pcd < f) ? f : pcd) + 2;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(int m, bit d, int pcd);
    mode = 2'(m);
    dual = d;
    hi   = FW'(pcd >> FW);
    lo   = FW'(pcd);
  endtask

  task automatic wait_strobe();
    int n = 0;
    @(negedge clk);
    while (!rise && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // called at a strobe negedge; counts cycles up to the next strobe
  task automatic count_period(output int per, output int hic);
    per = 0;
    hic = 0;
    do begin
      if (pclk) hic++;
      per++;
      @(negedge clk);
    end while (!rise && per < 5000);
  endtask

  task automatic run_case(string tag, int m, bit d, int pcd);
    int per, hic, e;
    set_cfg(m, d, pcd);
    wait_strobe();
    wait_strobe();
    chk({tag, " strobe during high (R8)"}, int'(pclk), 1);
    count_period(per, hic);
    e = exp_len(m, d, pcd);
    chk({tag, " period"}, per, e);
    chk({tag, " high phase (R2)"}, hic, e / 2);
  endtask

  initial begin
    int per, hic, ok;
    void'($urandom(32'h5A17));
    rst_n = 1'b0;
    byp   = 1'b0;
    set_cfg(3, 1'b0, 0);

    // R10: outputs low in reset, first strobe on the fourth edge after release
    ok = 1;
    repeat (5) begin
      @(negedge clk);
      if (pclk || rise) ok = 0;
    end
    chk("R10 low during reset", ok, 1);
    rst_n = 1'b1;
    ok = 1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      if (rise) ok = 0;
    end
    chk("R10 no early strobe", ok, 1);
    @(negedge clk);
    chk("R10 first strobe", int'(rise), 1);

    // directed
    run_case("R6 tft pcd0", 3, 1'b0, 0);
    run_case("R3 colour single", 0, 1'b0, 0);
    run_case("R3 colour dual", 0, 1'b1, 2);
    run_case("R4 mono4 single", 1, 1'b0, 0);
    run_case("R4 mono4 dual", 1, 1'b1, 5);
    run_case("R5 mono8 single", 2, 1'b0, 3);
    run_case("R5 mono8 dual", 2, 1'b1, 0);
    run_case("R5 above floor", 2, 1'b1, 20);
    run_case("R1 split fields", 3, 1'b0, (1 << FW) + 3);
    run_case("R1 max divisor", 0, 1'b0, 1023);

    // R9: change in mid-period keeps the running period
    set_cfg(0, 1'b0, 4);
    wait_strobe();
    wait_strobe();
    set_cfg(0, 1'b0, 10);
    count_period(per, hic);
    chk("R9 running period unchanged", per, 6);
    count_period(per, hic);
    chk("R9 new period", per, 12);

    // R7: bypass follows reference clock, strobe held high
    byp = 1'b1;
    ok = 1;
    repeat (6) begin
      @(posedge clk); #1;
      if (!pclk || !rise) ok = 0;
      @(negedge clk); #1;
      if (pclk || !rise) ok = 0;
    end
    chk("R7 bypass clock and strobe", ok, 1);
    byp = 1'b0;
    set_cfg(1, 1'b0, 7);
    @(negedge clk);
    chk("R7 no strobe first edge after exit", int'(rise), 0);
    @(negedge clk);
    chk("R7 strobe second edge after exit", int'(rise), 1);
    count_period(per, hic);
    chk("R7 period after exit", per, 9);

    // constrained random
    for (int i = 0; i < 24; i++) begin
      int m   = int'($urandom % 4);
      bit d   = 1'($urandom);
      int pcd = (i % 6 == 5) ? int'($urandom % 1024) : int'($urandom % 24);
      string tag;
      if (pcd < floor_of(m, d))
        tag = (m == 0) ? "R3 rand" : (m == 1) ? "R4 rand" : "R5 rand";
      else
        tag = "R1 rand";
      run_case(tag, m, d, pcd);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule